// File: doc/BRIEF.md
# Serial Flash Configuration Sequencer

This block prepares a serial NOR flash for fast quad-rate reads. A one-cycle pulse on `start` makes it run a fixed chain of single-line SPI transactions. Each transaction is framed by its own chip-select assertion, and bytes go out most significant bit first. The chain has two read-modify-write steps. The first sets the quad-enable bit (bit 1) of a configuration register. The second ORs a latency code into the dummy-cycle configuration register at register address 0x000003.

Before each write, the block sends a separate write-enable frame. After each write it polls status register 1 until the busy bit clears. If the flash stays busy for longer than a cycle budget, the sequence stops and reports an error.

Two build-time choices select the variant:
- Quad enable can be set through the legacy status/config pair (commands 0x05, 0x35 and 0x01), or through the generic any-register read and write commands (0x65 and 0x71) at address 0x800002.
- The latency write can target the non-volatile copy (offset 0x000000) or the volatile copy (offset 0x800000) of the register.

Top module: `qflash_cfg_seq`

## Requirements
- R1: After reset, `cs_n` is high, `sck` is low, and `done` and `err` are low. No transaction starts until `start` is pulsed.
- R2: The SPI link uses clock mode 0. `sck` idles low and every half period lasts CLK_DIV clock cycles. `mosi` changes only while `sck` is low. `miso` is sampled on the rising `sck` edge. Each byte goes out MSB first.
- R3: Between any two transactions, `cs_n` stays high for at least two `sck` periods (4*CLK_DIV clock cycles).
- R4: With QE_ANYREG=0, the block does the following in order:
  - reads status register 1 with frame 0x05 plus one byte in;
  - reads the config register with 0x35 plus one byte in;
  - writes with frame 0x01, then the status byte it read, then the config byte it read OR 0x02.
- R5: With QE_ANYREG=1, the block reads with frame 0x65 0x80 0x00 0x02 plus one byte in. It then writes with frame 0x71 0x80 0x00 0x02, followed by the byte it read OR 0x02.
- R6: The latency step reads with 0x65 A2 0x00 0x03 plus one byte in. It then writes 0x71 A2 0x00 0x03, followed by the byte it read OR LAT_CODE. A2 is 0x80 when LAT_VOLATILE=1 and 0x00 otherwise.
- R7: Every 0x01 or 0x71 write is directly preceded by a single-byte 0x06 frame of its own.
- R8: After each write, the block repeats the frame 0x05 plus one byte in until bit 0 of the returned byte is 0. Only then does the next step begin.
- R9: If the busy bit is still set on a poll that ends after POLL_LIMIT clock cycles of polling, the sequence stops with both `done` and `err` high, and no further frame is sent.
- R10: After a successful pass, `done` is high and `err` is low. Both hold until the next `start`. A `start` pulse during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a configuration pass |
| done | output | 1 | Pass finished (held until next start) |
| err | output | 1 | Busy-poll timeout occurred (held until next start) |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
The bench builds two instances side by side with CLK_DIV=2 and POLL_LIMIT=1500:
- One uses the legacy quad-enable path and a non-volatile latency target.
- The other uses the any-register quad-enable path and a volatile latency target.

Both instances are driven through a sweep of starting register contents, including a config byte that already has quad enable set, and busy durations from zero to three polls. This brings both frame layouts, both address offsets and the poll loop within reach. A flash that never leaves busy then exercises the timeout stop, and a mid-pass start pulse covers the ignore rule.

// File: rtl/qflash_cfg_pkg.sv
package qflash_cfg_pkg;
  localparam int unsigned MAX_TX = 5;
  localparam int unsigned TXW    = 8 * MAX_TX;

  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RDCFG = 8'h35;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDANY = 8'h65;
  localparam logic [7:0] OP_WRANY = 8'h71;
  localparam logic [7:0] QE_MASK  = 8'h02;
  localparam logic [23:0] QE_ADDR = 24'h800002;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_SR1, ST_RD_QE, ST_WREN1, ST_WR_QE, ST_POLL1,
    ST_RD_LAT, ST_WREN2, ST_WR_LAT, ST_POLL2
  } seq_state_t;
endpackage

// File: rtl/qflash_spi_shift.sv
module qflash_spi_shift import qflash_cfg_pkg::*; #(
  parameter int unsigned HALF = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [2:0]     tx_len,
  input  logic           rx_en,
  input  logic [TXW-1:0] tx_data,
  output logic           fin,
  output logic [7:0]     rx_byte,
  output logic           sck,
  output logic           cs_n,
  output logic           mosi,
  input  logic           miso
);
  localparam int unsigned GAP_CLKS = 4 * HALF;
  localparam int unsigned BITW = $clog2((MAX_TX + 1) * 8 + 1);
  localparam int unsigned DW   = $clog2(HALF + 1);
  localparam int unsigned GW   = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_t;
  eng_t            st;
  logic [TXW-1:0]  tx_sr;
  logic [BITW-1:0] bits_left;
  logic [DW-1:0]   div;
  logic [GW-1:0]   gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0; fin <= 1'b0;
      tx_sr <= '0; bits_left <= '0; div <= '0; gap <= '0; rx_byte <= '0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        E_IDLE: if (go) begin
          cs_n      <= 1'b0;
          tx_sr     <= tx_data;
          mosi      <= tx_data[TXW-1];
          bits_left <= BITW'((32'(tx_len) + (rx_en ? 32'd1 : 32'd0)) * 8);
          div       <= '0;
          st        <= E_SHIFT;
        end
        E_SHIFT: begin
          if (div == DW'(HALF - 1)) begin
            div <= '0;
            if (!sck) begin
              sck     <= 1'b1;
              rx_byte <= {rx_byte[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (bits_left == BITW'(1)) begin
                cs_n <= 1'b1; mosi <= 1'b0; gap <= '0; st <= E_GAP;
              end else begin
                bits_left <= bits_left - 1'b1;
                tx_sr     <= {tx_sr[TXW-2:0], 1'b0};
                mosi      <= tx_sr[TXW-2];
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        E_GAP: begin
          if (gap == GW'(GAP_CLKS - 1)) begin
            fin <= 1'b1; st <= E_IDLE;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // checker state: cycles cs_n has been high, saturating
  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= GW'(GAP_CLKS);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != GW'(GAP_CLKS)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_sck_low_deselected_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  p_mosi_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
  p_cs_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt == GW'(GAP_CLKS));
endmodule

// File: rtl/qflash_poll_timer.sv
module qflash_poll_timer #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0; expired <= 1'b0;
    end else begin
      if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
      expired <= (cnt == CW'(LIMIT));
    end
  end

  p_expire_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run));
endmodule

// File: rtl/qflash_cfg_seq.sv
module qflash_cfg_seq import qflash_cfg_pkg::*; #(
  parameter int unsigned CLK_DIV      = 2,
  parameter int unsigned POLL_LIMIT   = 100000,
  parameter logic [7:0]  LAT_CODE     = 8'h0A,
  parameter bit          QE_ANYREG    = 1'b0,
  parameter bit          LAT_VOLATILE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done,
  output logic err,
  output logic sck,
  output logic cs_n,
  output logic mosi,
  input  logic miso
);
  localparam logic [23:0] LAT_ADDR = {(LAT_VOLATILE ? 8'h80 : 8'h00), 16'h0003};

  seq_state_t     state;
  logic           go, launched, fin, tmo, polling;
  logic [7:0]     rx_byte, sr1_q, qe_q, lat_q;
  logic [TXW-1:0] frame;
  logic [2:0]     f_len;
  logic           f_rx;

  always_comb begin
    frame = '0; f_len = 3'd1; f_rx = 1'b0;
    unique case (state)
      ST_RD_SR1, ST_POLL1, ST_POLL2: begin frame[TXW-1 -: 8] = OP_RDSR; f_rx = 1'b1; end
      ST_RD_QE: begin
        f_rx = 1'b1;
        if (QE_ANYREG) begin frame[TXW-1 -: 32] = {OP_RDANY, QE_ADDR}; f_len = 3'd4; end
        else frame[TXW-1 -: 8] = OP_RDCFG;
      end
      ST_WREN1, ST_WREN2: frame[TXW-1 -: 8] = OP_WREN;
      ST_WR_QE: begin
        if (QE_ANYREG) begin frame = {OP_WRANY, QE_ADDR, qe_q | QE_MASK}; f_len = 3'd5; end
        else begin frame[TXW-1 -: 24] = {OP_WRSR, sr1_q, qe_q | QE_MASK}; f_len = 3'd3; end
      end
      ST_RD_LAT: begin frame[TXW-1 -: 32] = {OP_RDANY, LAT_ADDR}; f_len = 3'd4; f_rx = 1'b1; end
      ST_WR_LAT: begin frame = {OP_WRANY, LAT_ADDR, lat_q | LAT_CODE}; f_len = 3'd5; end
      default: ;
    endcase
  end

  assign polling = (state == ST_POLL1) || (state == ST_POLL2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; go <= 1'b0; launched <= 1'b0; done <= 1'b0; err <= 1'b0;
      sr1_q <= '0; qe_q <= '0; lat_q <= '0;
    end else begin
      go <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          done <= 1'b0; err <= 1'b0; launched <= 1'b0;
          state <= QE_ANYREG ? ST_RD_QE : ST_RD_SR1;
        end
      end else if (!launched) begin
        go <= 1'b1; launched <= 1'b1;
      end else if (fin) begin
        launched <= 1'b0;
        unique case (state)
          ST_RD_SR1: begin sr1_q <= rx_byte; state <= ST_RD_QE; end
          ST_RD_QE:  begin qe_q <= rx_byte; state <= ST_WREN1; end
          ST_WREN1:  state <= ST_WR_QE;
          ST_WR_QE:  state <= ST_POLL1;
          ST_RD_LAT: begin lat_q <= rx_byte; state <= ST_WREN2; end
          ST_WREN2:  state <= ST_WR_LAT;
          ST_WR_LAT: state <= ST_POLL2;
          ST_POLL1, ST_POLL2: begin
            if (!rx_byte[0]) begin
              state <= (state == ST_POLL1) ? ST_RD_LAT : ST_IDLE;
              done  <= (state == ST_POLL2);
            end else if (tmo) begin
              state <= ST_IDLE; done <= 1'b1; err <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  qflash_spi_shift #(.HALF(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx_len(f_len), .rx_en(f_rx), .tx_data(frame),
    .fin(fin), .rx_byte(rx_byte), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  qflash_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .run(polling), .expired(tmo)
  );

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_timeout_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(tmo));
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n);
  p_done_clear_by_start_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(start));
  p_write_after_wren_r7: assert property (@(posedge clk) disable iff (rst)
    ($changed(state) && (state == ST_WR_QE || state == ST_WR_LAT))
      |-> ($past(state) == ST_WREN1 || $past(state) == ST_WREN2));
endmodule

// File: tb/qflash_cfg_seq_test.sv
module flash_model #(parameter longint MIN_GAP = 80) (
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       load,
  input  logic [7:0] i_sr1,
  input  logic [7:0] i_cr,
  input  logic [7:0] i_latnv,
  input  logic [7:0] i_latv,
  input  logic [7:0] i_busy,
  output logic       miso
);
  logic [7:0] fr [0:7];
  int nbits = 0;
  logic [7:0] sr1, cr, lat_nv, lat_v, busy_left;
  logic wel;
  int polls, writes, viol;
  int gap_viol = 0;
  longint last_rise = 0;

  initial miso = 1'b0;

  always @(posedge sck or negedge cs_n) begin
    if (!sck) nbits = 0;
    else if (!cs_n && nbits < 64) begin
      fr[nbits / 8][7 - (nbits % 8)] = mosi;
      nbits++;
    end
  end

  always @(negedge cs_n)
    if (($time - last_rise) < MIN_GAP) gap_viol++;

  always @(negedge sck) begin
    if (!cs_n && nbits >= 8) begin
      int st;
      logic [7:0] rsp;
      logic [23:0] a;
      st = 8; rsp = 8'h00;
      a = {fr[1], fr[2], fr[3]};
      case (fr[0])
        8'h05: rsp = {sr1[7:1], busy_left != 8'h00};
        8'h35: rsp = cr;
        8'h65: begin
          st = 32;
          case (a)
            24'h000002, 24'h800002: rsp = cr;
            24'h000003: rsp = lat_nv;
            24'h800003: rsp = lat_v;
            default: rsp = 8'h00;
          endcase
        end
        default: ;
      endcase
      if (nbits >= st && nbits < st + 8) miso = rsp[7 - (nbits - st)];
    end
  end

  always @(posedge load or posedge cs_n) begin
    if (load) begin
      sr1 = i_sr1; cr = i_cr; lat_nv = i_latnv; lat_v = i_latv;
      busy_left = 8'h00; wel = 1'b0; polls = 0; writes = 0; viol = 0;
    end else begin
      last_rise = $time;
      case (fr[0])
        8'h06: if (nbits == 8) wel = 1'b1; else viol++;
        8'h05: begin
          polls++;
          if (busy_left != 8'h00 && busy_left != 8'hFF) busy_left--;
        end
        8'h35, 8'h65: ;
        8'h01: if (wel && nbits == 24) begin
          sr1 = fr[1]; cr = fr[2]; wel = 1'b0; writes++; busy_left = i_busy;
        end else viol++;
        8'h71: if (wel && nbits == 40) begin
          case ({fr[1], fr[2], fr[3]})
            24'h000002, 24'h800002: cr = fr[4];
            24'h000003: lat_nv = fr[4];
            24'h800003: lat_v = fr[4];
            default: viol++;
          endcase
          wel = 1'b0; writes++; busy_left = i_busy;
        end else viol++;
        default: viol++;
      endcase
    end
  end
endmodule

module qflash_cfg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam logic [7:0] LCODE = 8'h0A;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, load = 1'b0;
  logic done_a, err_a, sck_a, cs_a, mosi_a, miso_a;
  logic done_b, err_b, sck_b, cs_b, mosi_b, miso_b;
  logic [7:0] i_sr1 = 0, i_cr = 0, i_latnv = 0, i_latv = 0, i_busy = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qflash_cfg_seq #(.CLK_DIV(DIV), .POLL_LIMIT(1500), .LAT_CODE(LCODE),
                   .QE_ANYREG(1'b0), .LAT_VOLATILE(1'b0)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done_a), .err(err_a),
    .sck(sck_a), .cs_n(cs_a), .mosi(mosi_a), .miso(miso_a));
  qflash_cfg_seq #(.CLK_DIV(DIV), .POLL_LIMIT(1500), .LAT_CODE(LCODE),
                   .QE_ANYREG(1'b1), .LAT_VOLATILE(1'b1)) uut_b (
    .clk(clk), .rst(rst), .start(start), .done(done_b), .err(err_b),
    .sck(sck_b), .cs_n(cs_b), .mosi(mosi_b), .miso(miso_b));

  flash_model #(.MIN_GAP(4 * DIV * CLK_PERIOD)) mdl_a (
    .sck(sck_a), .cs_n(cs_a), .mosi(mosi_a), .load(load), .i_sr1(i_sr1), .i_cr(i_cr),
    .i_latnv(i_latnv), .i_latv(i_latv), .i_busy(i_busy), .miso(miso_a));
  flash_model #(.MIN_GAP(4 * DIV * CLK_PERIOD)) mdl_b (
    .sck(sck_b), .cs_n(cs_b), .mosi(mosi_b), .load(load), .i_sr1(i_sr1), .i_cr(i_cr),
    .i_latnv(i_latnv), .i_latv(i_latv), .i_busy(i_busy), .miso(miso_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_both();
    int n;
    n = 0;
    while (!(done_a && done_b) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) begin
      chk(1'b0, "R10 watchdog", n, 20000);
      finish_up();
    end
  endtask

  task automatic load_model();
    #1 load = 1'b1;
    #1 load = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    // R1: reset state and idle without start
    chk(cs_a === 1'b1 && cs_b === 1'b1, "R1 cs_n high", {cs_a, cs_b}, 2'b11);
    chk(sck_a === 1'b0 && sck_b === 1'b0, "R1 sck low", {sck_a, sck_b}, 0);
    chk(done_a === 1'b0 && done_b === 1'b0, "R1 done low", {done_a, done_b}, 0);
    chk(err_a === 1'b0 && err_b === 1'b0, "R1 err low", {err_a, err_b}, 0);

    for (int s = 0; s < 4; s++) begin
      i_cr    = 8'(s * 8'h53);
      i_sr1   = 8'(s * 8'h24) & 8'hFC;
      i_latnv = 8'(8'hF0 >> s);
      i_latv  = 8'(8'h31 << s);
      i_busy  = 8'(s);
      load_model();
      pulse_start();
      if (s == 1) begin
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      wait_both();
      // instance A: legacy QE path, non-volatile latency
      chk(done_a && !err_a, "R10 A done ok", {done_a, err_a}, 2'b10);
      chk(mdl_a.cr == (i_cr | 8'h02), "R4 A quad enable", mdl_a.cr, i_cr | 8'h02);
      chk(mdl_a.sr1 == i_sr1, "R4 A status kept", mdl_a.sr1, i_sr1);
      chk(mdl_a.lat_nv == (i_latnv | LCODE), "R6 A latency nv", mdl_a.lat_nv, i_latnv | LCODE);
      chk(mdl_a.lat_v == i_latv, "R6 A volatile untouched", mdl_a.lat_v, i_latv);
      chk(mdl_a.polls == 1 + 2 * (s + 1), "R8 A polls", mdl_a.polls, 1 + 2 * (s + 1));
      chk(mdl_a.writes == 2 && mdl_a.viol == 0, "R7 R10 A writes", mdl_a.writes * 16 + mdl_a.viol, 32);
      // instance B: any-register QE path, volatile latency
      chk(done_b && !err_b, "R10 B done ok", {done_b, err_b}, 2'b10);
      chk(mdl_b.cr == (i_cr | 8'h02), "R5 B quad enable", mdl_b.cr, i_cr | 8'h02);
      chk(mdl_b.lat_v == (i_latv | LCODE), "R6 B latency v", mdl_b.lat_v, i_latv | LCODE);
      chk(mdl_b.lat_nv == i_latnv, "R6 B nv untouched", mdl_b.lat_nv, i_latnv);
      chk(mdl_b.polls == 2 * (s + 1), "R8 B polls", mdl_b.polls, 2 * (s + 1));
      chk(mdl_b.writes == 2 && mdl_b.viol == 0, "R7 R10 B writes", mdl_b.writes * 16 + mdl_b.viol, 32);
      repeat (20) @(negedge clk);
      chk(done_a && done_b && cs_a && cs_b, "R10 done held", {done_a, done_b, cs_a, cs_b}, 4'hF);
    end

    // R9: flash never leaves busy
    i_cr = 8'h40; i_sr1 = 8'h00; i_latnv = 8'h11; i_latv = 8'h22; i_busy = 8'hFF;
    load_model();
    pulse_start();
    wait_both();
    chk(done_a && err_a, "R9 A timeout flags", {done_a, err_a}, 2'b11);
    chk(done_b && err_b, "R9 B timeout flags", {done_b, err_b}, 2'b11);
    chk(mdl_a.writes == 1 && mdl_a.lat_nv == 8'h11, "R9 A stopped", mdl_a.writes, 1);
    chk(mdl_b.writes == 1 && mdl_b.lat_v == 8'h22, "R9 B stopped", mdl_b.writes, 1);
    chk(mdl_a.cr == 8'h42 && mdl_b.cr == 8'h42, "R9 QE written", mdl_a.cr, 8'h42);
    repeat (200) @(negedge clk);
    chk(cs_a && cs_b, "R9 no frame after stop", {cs_a, cs_b}, 2'b11);

    chk(mdl_a.gap_viol == 0 && mdl_b.gap_viol == 0, "R3 cs gap",
        mdl_a.gap_viol + mdl_b.gap_viol, 0);
    // R2 is covered by byte values matching across MSB-first framing above
    finish_up();
  end
endmodule